// File: doc/BRIEF.md
# Supply Bring-Up and Brown-Out Sequencer

This block brings a chip out of reset and then watches its supply. It leaves the power-on flops on an asynchronous power-good reset. After the external active-low reset input goes high, it runs a long wait and then checks the supply against a fixed default threshold. Once that check passes it enables the core regulators. A second long wait follows. The block then strobes the fuse array for a stored threshold code and applies that code to the monitor. After a short pause it checks the supply a second time, and only if that check passes does it release the internal reset to the CPU and peripherals.

Once the core is running, a supply dip has one of two effects, chosen by a mode input. In one mode it puts the chip back through the full sequence. In the other it sets a sticky interrupt flag on the chosen crossing edge, and software clears that flag with a write-one-to-clear pulse. A software reset request also re-runs the whole sequence, and software may rewrite the threshold code while the core runs. The comparator, the regulators and the fuse array lie outside the block and appear only as plain signals.

Top module: `pwr_seq_top`

## Requirements
- R1: While `ext_rst_n` is low, the sequencer is held at its idle state from the next clock on. In that state `core_rst_n`, `reg_en` and `fuse_rd` are 0 and `thr_sel` is 4. `por_n` low clears every flop asynchronously to the same state.
- R2: After `ext_rst_n` goes high there is one idle cycle and then a wait of LONG_CYC cycles, where LONG_CYC = LONG_TENTHS*CLK_PER_UNIT/10 (52 by default). The synchronised comparator is then checked with `thr_sel` = 4, and `reg_en` rises on the clock after the first passing check.
- R3: A failed supply check, whether the first or the second, holds the sequencer in that check and re-tests it every cycle. It never goes back to idle.
- R4: After `reg_en` rises there is a second wait of LONG_CYC cycles. `fuse_rd` is then held high until a cycle in which `fuse_done` is 1, and `fuse_rd` is never high without `reg_en`.
- R5: In the cycle where `fuse_done` is seen, `thr_sel` takes `fuse_code` if `fuse_valid` is 1. Otherwise it takes the default code 4 (2.3 V).
- R6: After a pause of SHORT_CYC = SHORT_TENTHS*CLK_PER_UNIT/10 cycles (10 by default), the supply is checked at the new threshold. `core_rst_n` rises on the clock after the first passing check.
- R7: `cmp_above_raw` passes through a two-flop synchroniser, so a change that is stable before clock edge k drives decisions made at edge k+2.
- R8: `thr_sel` codes 0 to 7 select 1.95, 2.0, 2.1, 2.2, 2.3, 2.4, 2.7 and 3.0 V. A `sw_thr_wr` pulse while `core_rst_n` is 1 loads `sw_thr_code` on the next clock, and the pulse is ignored at any other time.
- R9: With `dip_irq_mode` = 0 and `core_rst_n` = 1, a synchronised comparator value of 0 drops `core_rst_n` and `reg_en` on the next clock and restarts the sequence with `thr_sel` = 4.
- R10: With `dip_irq_mode` = 1 while running, a synchronised edge sets `supply_irq`. The edge is falling when `irq_on_rise` = 0 and rising when `irq_on_rise` = 1. With `dip_irq_mode` = 0, `supply_irq` is never set.
- R11: `supply_irq` stays set until an `irq_clr` pulse clears it on the next clock. A set event in the same cycle wins over the clear, and the flag is cleared whenever the core is not running.
- R12: A `sw_rst_req` pulse while running returns the sequencer to idle on the next clock (`core_rst_n` = 0, `reg_en` = 0, `thr_sel` = 4), and the full sequence runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Asynchronous power-good reset, active low |
| ext_rst_n | input | 1 | External reset, active low, sampled on clk |
| sw_rst_req | input | 1 | Software full-chip reset pulse |
| cmp_above_raw | input | 1 | Unsynchronised comparator: supply above selected threshold |
| fuse_code | input | 3 | Threshold code read from fuses |
| fuse_valid | input | 1 | Fuse threshold field is programmed |
| fuse_done | input | 1 | Fuse read completed |
| sw_thr_wr | input | 1 | Software threshold write strobe |
| sw_thr_code | input | 3 | Software threshold code |
| dip_irq_mode | input | 1 | 0: dip resets the chip, 1: dip raises interrupt |
| irq_on_rise | input | 1 | Interrupt edge: 0 falling, 1 rising |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| thr_sel | output | 3 | Threshold select to the comparator |
| reg_en | output | 1 | Core regulator enable |
| fuse_rd | output | 1 | Fuse read strobe |
| core_rst_n | output | 1 | Internal reset to CPU and peripherals, active low |
| supply_irq | output | 1 | Sticky supply-crossing interrupt |

## Verification
The bench holds the comparator low through the first check for longer than a full wait. A design that restarted on a failure, or that enabled the regulators early, would then show `reg_en` out of step with the model. The bench brings the chip up twice, once with a programmed fuse code and once with `fuse_valid` low while `fuse_code` carries a non-default value, which exposes a design that loads fuse data it should ignore. It also writes thresholds outside the run state, where they must have no effect. It times interrupt edges against the two-flop delay, so a design with one synchroniser stage too many or too few would flag the edge on the wrong cycle. It also drives a dip in reset mode, where a design must restart the chip and must not raise the flag.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int unsigned THR_W = 3;
  localparam logic [THR_W-1:0] THR_DEFAULT = 3'd4;  // 2.3 V

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_WAIT1,
    PS_CHK1,
    PS_WAIT2,
    PS_FUSE,
    PS_PAUSE,
    PS_CHK2,
    PS_RUN
  } pseq_state_t;

  // Converts a duration in tenths of a time unit into clock cycles, at least one.
  function automatic int unsigned scale_cycles(input int unsigned tenths,
                                               input int unsigned per_unit);
    int unsigned c;
    c = (tenths * per_unit) / 10;
    return (c == 0) ? 1 : c;
  endfunction

  // Threshold actually applied after the fuse read.
  function automatic logic [THR_W-1:0] pick_fuse_thr(input logic valid,
                                                     input logic [THR_W-1:0] code);
    return valid ? code : THR_DEFAULT;
  endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_stage_timer.sv
module pwr_stage_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = run && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || done)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwr_supply_irq.sv
module pwr_supply_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic enable,
  input  logic on_rise,
  input  logic cmp_sync,
  input  logic clr,
  output logic irq,
  output logic set_evt
);
  logic cmp_prev;
  logic rise_evt;
  logic fall_evt;

  assign rise_evt = cmp_sync & ~cmp_prev;
  assign fall_evt = ~cmp_sync & cmp_prev;
  assign set_evt  = active & enable & (on_rise ? rise_evt : fall_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_prev <= 1'b0;
      irq      <= 1'b0;
    end else begin
      cmp_prev <= cmp_sync;
      if (!active)      irq <= 1'b0;
      else if (set_evt) irq <= 1'b1;
      else if (clr)     irq <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CLK_PER_UNIT = 4,
  parameter int unsigned LONG_TENTHS  = 130,
  parameter int unsigned SHORT_TENTHS = 25,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ext_rst_n,
  input  logic             sw_rst_req,
  input  logic             cmp_above_raw,
  input  logic [THR_W-1:0] fuse_code,
  input  logic             fuse_valid,
  input  logic             fuse_done,
  input  logic             sw_thr_wr,
  input  logic [THR_W-1:0] sw_thr_code,
  input  logic             dip_irq_mode,
  input  logic             irq_on_rise,
  input  logic             irq_clr,
  output logic [THR_W-1:0] thr_sel,
  output logic             reg_en,
  output logic             fuse_rd,
  output logic             core_rst_n,
  output logic             supply_irq
);
  localparam int unsigned LONG_CYC  = scale_cycles(LONG_TENTHS, CLK_PER_UNIT);
  localparam int unsigned SHORT_CYC = scale_cycles(SHORT_TENTHS, CLK_PER_UNIT);
  localparam int unsigned MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  pseq_state_t      state;
  logic [THR_W-1:0] thr_q;
  logic [CNT_W-1:0] limit;
  logic             tmr_run;
  logic             tmr_done;

  // Named internal events, also used by the bound checker.
  logic cmp_sync;
  logic chk1_pass;
  logic chk2_pass;
  logic dip_reset;
  logic irq_set;
  logic running;

  pwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (cmp_above_raw),
    .q     (cmp_sync)
  );

  assign tmr_run = (state == PS_WAIT1) || (state == PS_WAIT2) || (state == PS_PAUSE);
  assign limit   = (state == PS_PAUSE) ? CNT_W'(SHORT_CYC) : CNT_W'(LONG_CYC);

  pwr_stage_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (por_n),
    .run   (tmr_run),
    .limit (limit),
    .done  (tmr_done)
  );

  assign running   = (state == PS_RUN);
  assign chk1_pass = (state == PS_CHK1) && cmp_sync;
  assign chk2_pass = (state == PS_CHK2) && cmp_sync;
  assign dip_reset = running && !dip_irq_mode && !cmp_sync;

  pwr_supply_irq u_irq (
    .clk      (clk),
    .rst_n    (por_n),
    .active   (running),
    .enable   (dip_irq_mode),
    .on_rise  (irq_on_rise),
    .cmp_sync (cmp_sync),
    .clr      (irq_clr),
    .irq      (supply_irq),
    .set_evt  (irq_set)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state <= PS_IDLE;
      thr_q <= THR_DEFAULT;
    end else if (!ext_rst_n) begin
      state <= PS_IDLE;
      thr_q <= THR_DEFAULT;
    end else begin
      unique case (state)
        PS_IDLE:  state <= PS_WAIT1;
        PS_WAIT1: if (tmr_done) state <= PS_CHK1;
        PS_CHK1:  if (chk1_pass) state <= PS_WAIT2;
        PS_WAIT2: if (tmr_done) state <= PS_FUSE;
        PS_FUSE: begin
          if (fuse_done) begin
            thr_q <= pick_fuse_thr(fuse_valid, fuse_code);
            state <= PS_PAUSE;
          end
        end
        PS_PAUSE: if (tmr_done) state <= PS_CHK2;
        PS_CHK2:  if (chk2_pass) state <= PS_RUN;
        PS_RUN: begin
          if (sw_rst_req || dip_reset) begin
            state <= PS_IDLE;
            thr_q <= THR_DEFAULT;
          end else if (sw_thr_wr) begin
            thr_q <= sw_thr_code;
          end
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  assign thr_sel    = thr_q;
  assign fuse_rd    = (state == PS_FUSE);
  assign core_rst_n = running;
  assign reg_en     = (state == PS_WAIT2) || (state == PS_FUSE) || (state == PS_PAUSE) ||
                      (state == PS_CHK2)  || running;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic clk,
  input logic por_n,
  input logic ext_rst_n,
  input logic dip_irq_mode,
  input logic irq_clr,
  input logic cmp_sync,
  input logic chk1_pass,
  input logic chk2_pass,
  input logic irq_set,
  input logic reg_en,
  input logic fuse_rd,
  input logic core_rst_n,
  input logic supply_irq
);
  assert_ext_hold_R1: assert property (@(posedge clk) disable iff (!por_n)
    !ext_rst_n |=> (!core_rst_n && !reg_en && !fuse_rd));

  assert_regen_after_check_R2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(reg_en) |-> $past(chk1_pass));

  assert_fuse_needs_reg_R4: assert property (@(posedge clk) disable iff (!por_n)
    fuse_rd |-> reg_en);

  assert_release_after_check_R6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst_n) |-> $past(chk2_pass));

  assert_dip_resets_R9: assert property (@(posedge clk) disable iff (!por_n)
    (core_rst_n && ext_rst_n && !dip_irq_mode && !cmp_sync) |=> !core_rst_n);

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!por_n)
    $rose(supply_irq) |-> ($past(dip_irq_mode) && $past(core_rst_n)));

  assert_irq_clear_R11: assert property (@(posedge clk) disable iff (!por_n)
    (irq_clr && !irq_set) |=> !supply_irq);
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (.*);

// File: tb/sim_pwr_seq_top.sv
module sim_pwr_seq_top;
  localparam int LONG  = 130 * 4 / 10;
  localparam int SHORT = 25 * 4 / 10;

  logic clk = 1'b0;
  logic por_n = 1'b0, ext_rst_n = 1'b0, sw_rst_req = 1'b0, cmp_above_raw = 1'b0;
  logic [2:0] fuse_code = 3'd0, sw_thr_code = 3'd0;
  logic fuse_valid = 1'b0, fuse_done = 1'b0, sw_thr_wr = 1'b0;
  logic dip_irq_mode = 1'b1, irq_on_rise = 1'b0, irq_clr = 1'b0;
  logic [2:0] thr_sel;
  logic reg_en, fuse_rd, core_rst_n, supply_irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwr_seq_top u0 (.*);

  // Behavioural reference model: phase index plus a countdown.
  bit m_s1, m_s2, m_prev, m_irq, so, po;
  int m_ph, m_left, ph;
  logic [2:0] m_thr;

  always @(posedge clk) begin
    if (!por_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_irq = 0; m_ph = 0; m_left = 0; m_thr = 3'd4;
    end else begin
      so = m_s2; po = m_prev; ph = m_ph;
      m_s2 = m_s1; m_s1 = cmp_above_raw; m_prev = so;
      if (ph != 7) m_irq = 0;
      else if (dip_irq_mode && (irq_on_rise ? (so && !po) : (!so && po))) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      if (!ext_rst_n) begin
        m_ph = 0; m_thr = 3'd4;
      end else begin
        case (ph)
          0: begin m_ph = 1; m_left = LONG; end
          1: begin m_left--; if (m_left == 0) m_ph = 2; end
          2: if (so) begin m_ph = 3; m_left = LONG; end
          3: begin m_left--; if (m_left == 0) m_ph = 4; end
          4: if (fuse_done) begin m_thr = fuse_valid ? fuse_code : 3'd4; m_ph = 5; m_left = SHORT; end
          5: begin m_left--; if (m_left == 0) m_ph = 6; end
          6: if (so) m_ph = 7;
          default: begin
            if (sw_rst_req || (!dip_irq_mode && !so)) begin m_ph = 0; m_thr = 3'd4; end
            else if (sw_thr_wr) m_thr = sw_thr_code;
          end
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (por_n && !finished) begin
      chk(reg_en == (m_ph >= 3), "R2 reg_en", reg_en, m_ph >= 3);
      chk(fuse_rd == (m_ph == 4), "R4 fuse_rd", fuse_rd, m_ph == 4);
      chk(core_rst_n == (m_ph == 7), "R6 core_rst_n", core_rst_n, m_ph == 7);
      chk(thr_sel == m_thr, "R5 thr_sel", thr_sel, m_thr);
      chk(supply_irq == m_irq, "R10 supply_irq", supply_irq, m_irq);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fuse_reply();
    for (int i = 0; i < 400 && !fuse_rd; i++) step(1);
    step(3);
    fuse_done = 1'b1;
    step(1);
    fuse_done = 1'b0;
  endtask

  task automatic wait_core();
    for (int i = 0; i < 400 && !core_rst_n; i++) step(1);
  endtask

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step(2);
    chk(core_rst_n == 0 && reg_en == 0 && thr_sel == 3'd4, "R1 por state", core_rst_n, 0);
    por_n = 1'b1;
    step(5);
    chk(core_rst_n == 0 && reg_en == 0 && fuse_rd == 0, "R1 ext held", reg_en, 0);

    // Bring-up 1: comparator fails first check for a while; fuse code 6 programmed.
    fuse_valid = 1'b1; fuse_code = 3'd6;
    ext_rst_n = 1'b1;
    step(LONG + 40);
    chk(reg_en == 0, "R3 hold in failed check", reg_en, 0);
    chk(thr_sel == 3'd4, "R2 default threshold", thr_sel, 4);
    cmp_above_raw = 1'b1;
    fuse_reply();
    wait_core();
    chk(core_rst_n == 1, "R6 released", core_rst_n, 1);
    chk(thr_sel == 3'd6, "R5 fuse code applied", thr_sel, 6);

    // Software threshold write while running.
    sw_thr_code = 3'd1; sw_thr_wr = 1'b1; step(1); sw_thr_wr = 1'b0;
    chk(thr_sel == 3'd1, "R8 sw write", thr_sel, 1);

    // Falling edge interrupt and synchroniser delay.
    cmp_above_raw = 1'b0;
    step(2);
    chk(supply_irq == 0, "R7 not yet", supply_irq, 0);
    step(1);
    chk(supply_irq == 1, "R7 after two stages", supply_irq, 1);
    step(3);
    chk(supply_irq == 1, "R11 sticky", supply_irq, 1);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    chk(supply_irq == 0, "R11 cleared", supply_irq, 0);

    // Rising-edge polarity.
    irq_on_rise = 1'b1;
    cmp_above_raw = 1'b1;
    step(4);
    chk(supply_irq == 1, "R10 rise edge", supply_irq, 1);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;

    // Software reset and second bring-up without a programmed fuse.
    sw_rst_req = 1'b1; step(1); sw_rst_req = 1'b0;
    chk(core_rst_n == 0 && reg_en == 0, "R12 sw reset", reg_en, 0);
    chk(thr_sel == 3'd4, "R12 default restored", thr_sel, 4);
    chk(supply_irq == 0, "R11 cleared off run", supply_irq, 0);
    step(3);
    sw_thr_code = 3'd7; sw_thr_wr = 1'b1; step(1); sw_thr_wr = 1'b0;
    chk(thr_sel == 3'd4, "R8 write ignored", thr_sel, 4);
    fuse_valid = 1'b0; fuse_code = 3'd6;
    fuse_reply();
    wait_core();
    chk(core_rst_n == 1 && thr_sel == 3'd4, "R5 unprogrammed default", thr_sel, 4);

    // Reset-mode dip.
    dip_irq_mode = 1'b0; irq_on_rise = 1'b0;
    step(2);
    cmp_above_raw = 1'b0;
    step(3);
    chk(core_rst_n == 0 && reg_en == 0, "R9 dip reset", core_rst_n, 0);
    chk(supply_irq == 0, "R10 no irq in reset mode", supply_irq, 0);

    // External reset mid-sequence.
    cmp_above_raw = 1'b1;
    step(LONG + 10);
    ext_rst_n = 1'b0;
    step(2);
    chk(reg_en == 0 && thr_sel == 3'd4, "R1 ext reset mid sequence", reg_en, 0);
    step(2);
    summary();
  end
endmodule